// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block works out where control goes after a control-transfer instruction in a 32-bit load/store core whose architecture has one delay slot. It takes the address of the current instruction, the decoded instruction fields (major opcode, the two source register numbers, the destination register number, the function code, a 16-bit displacement and a 26-bit word index) and the values already read from the two source registers. All outputs are combinational and settle in the same cycle.

It reports whether control is redirected and gives the redirect address. It also gives the address of the next instruction to fetch, which is the redirect address when control is redirected and the sequential address otherwise. For the call forms it raises a link write request with the destination register and the return address. The return address skips the delay slot, because the instruction that follows the branch is always executed. The caller handles fetch, squashing and exceptions.

Top module: `cti_next_pc`

## Requirements
- R1: Opcode 4 is taken when the rs and rt values are equal. Opcode 5 is taken when they differ.
- R2: Opcode 6 is taken when the rs value, read as signed, is zero or negative. Opcode 7 is taken when it is strictly positive. The rt value has no effect on either.
- R3: Opcode 1 uses the rt register number as a sub-code. rt=1 is taken when rs is signed non-negative, and rt=0 is taken when rs is negative. Any other rt number under opcode 1 is never taken and never links.
- R4: A conditional branch targets PC+4 plus the sign-extended 16-bit displacement shifted left by 2. A displacement of -4 gives PC-12.
- R5: Opcode 2 (plain jump) and opcode 3 (jump and link) are always taken. Their target is bits 31:28 of PC+4, followed by the 26-bit index, followed by two zero bits. For example, index 24 at PC 0x80000000 gives 0x80000060.
- R6: Opcode 0 with function 8 (register jump) and opcode 0 with function 9 (register jump and link) are always taken, and their target is the rs value unchanged.
- R7: Opcode 3 requests a link write to register 31. Opcode 0 with function 9 requests a link write to the rd register. In both cases the return address is PC+8. No other instruction requests a link write.
- R8: The next-fetch output equals the target when taken and PC+4 when not taken.
- R9: An instruction outside the classes above is never taken and never links. This covers opcode 0 with any function other than 8 or 9, and any opcode other than 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the control-transfer instruction |
| opcode_i | input | 6 | Major opcode field |
| rs_idx_i | input | 5 | First source register number |
| rt_idx_i | input | 5 | Second source register number, which is the sub-code under opcode 1 |
| rd_idx_i | input | 5 | Destination register number for the register call form |
| funct_i | input | 6 | Function field used under opcode 0 |
| offset_i | input | 16 | Branch displacement in words |
| index_i | input | 26 | Absolute jump word index |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| taken_o | output | 1 | Control is redirected |
| target_o | output | 32 | Redirect address for the decoded class |
| next_pc_o | output | 32 | Next address to fetch |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | 5 | Link destination register number |
| link_addr_o | output | 32 | Return address written on a link |

## Verification
The block holds no state, so a decode or compare fault shows up at the ports in the same cycle as the instruction that triggers it. A misclassified opcode or sub-code shows as a wrong taken flag or a spurious link request. A wrong sign test shows only at the signed boundaries, which are zero, minus one and the most negative value. A faulty displacement extension shows only for negative offsets. An off-by-one in the sequential adder shows in both next_pc_o and link_addr_o. The stimulus therefore covers these boundaries, equal and unequal operands, and every rt sub-code under opcode 1.

// File: rtl/cti_pkg.sv
package cti_pkg;
   localparam logic [5:0] OP_SPECIAL = 6'd0;
   localparam logic [5:0] OP_REGIMM  = 6'd1;
   localparam logic [5:0] OP_JUMP    = 6'd2;
   localparam logic [5:0] OP_CALL    = 6'd3;
   localparam logic [5:0] OP_EQ      = 6'd4;
   localparam logic [5:0] OP_NE      = 6'd5;
   localparam logic [5:0] OP_LEZ     = 6'd6;
   localparam logic [5:0] OP_GTZ     = 6'd7;
   localparam logic [5:0] FN_RJUMP   = 6'd8;
   localparam logic [5:0] FN_RCALL   = 6'd9;
   localparam logic [4:0] RI_LTZ     = 5'd0;
   localparam logic [4:0] RI_GEZ     = 5'd1;

   typedef enum logic [3:0] {
      K_NONE, K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ,
      K_JUMP, K_CALL, K_RJUMP, K_RCALL
   } cti_kind_e;

   function automatic logic kind_is_cond(cti_kind_e k);
      return (k == K_EQ) || (k == K_NE) || (k == K_LEZ) ||
             (k == K_GTZ) || (k == K_LTZ) || (k == K_GEZ);
   endfunction
endpackage

// File: rtl/cti_decode.sv
module cti_decode
   import cti_pkg::*;
#(
   parameter int REG_IDX_W = 5
) (
   input  logic [5:0]           opcode_i,
   input  logic [REG_IDX_W-1:0] rt_idx_i,
   input  logic [5:0]           funct_i,
   output cti_kind_e            kind_o
);
   always_comb begin
      kind_o = K_NONE;
      unique case (opcode_i)
         OP_SPECIAL: begin
            if (funct_i == FN_RJUMP)      kind_o = K_RJUMP;
            else if (funct_i == FN_RCALL) kind_o = K_RCALL;
         end
         OP_REGIMM: begin
            if (rt_idx_i == REG_IDX_W'(RI_GEZ))      kind_o = K_GEZ;
            else if (rt_idx_i == REG_IDX_W'(RI_LTZ)) kind_o = K_LTZ;
         end
         OP_JUMP: kind_o = K_JUMP;
         OP_CALL: kind_o = K_CALL;
         OP_EQ:   kind_o = K_EQ;
         OP_NE:   kind_o = K_NE;
         OP_LEZ:  kind_o = K_LEZ;
         OP_GTZ:  kind_o = K_GTZ;
         default: kind_o = K_NONE;
      endcase
   end

   // R3: a regimm sub-code other than 0 or 1 must decode to no transfer
   always_comb begin
      if (opcode_i == OP_REGIMM && rt_idx_i > REG_IDX_W'(1))
         p_regimm_other_r3: assert (kind_o == K_NONE);
   end
endmodule

// File: rtl/cti_cond.sv
module cti_cond
   import cti_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  cti_kind_e         kind_i,
   input  logic [DATA_W-1:0] rs_val_i,
   input  logic [DATA_W-1:0] rt_val_i,
   output logic              taken_o
);
   logic neg, zero;
   assign neg  = rs_val_i[DATA_W-1];
   assign zero = (rs_val_i == '0);

   always_comb begin
      unique case (kind_i)
         K_EQ:    taken_o = (rs_val_i == rt_val_i);
         K_NE:    taken_o = (rs_val_i != rt_val_i);
         K_LEZ:   taken_o = neg | zero;
         K_GTZ:   taken_o = ~neg & ~zero;
         K_LTZ:   taken_o = neg;
         K_GEZ:   taken_o = ~neg;
         K_JUMP, K_CALL, K_RJUMP, K_RCALL: taken_o = 1'b1;
         default: taken_o = 1'b0;
      endcase
   end

   // R2: a strictly positive rs can never take a less-or-equal-zero branch
   always_comb begin
      if (kind_i == K_LEZ && $signed(rs_val_i) > 0)
         p_lez_positive_r2: assert (!taken_o);
   end
endmodule

// File: rtl/cti_target.sv
module cti_target
   import cti_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 16,
   parameter int IDX_W      = 26,
   parameter bit DELAY_SLOT = 1'b1
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  cti_kind_e         kind_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic [IDX_W-1:0]  index_i,
   input  logic [ADDR_W-1:0] rs_val_i,
   output logic [ADDR_W-1:0] seq_pc_o,
   output logic [ADDR_W-1:0] target_o,
   output logic [ADDR_W-1:0] link_addr_o
);
   localparam int WORD_SH  = 2;
   localparam int REGION_W = ADDR_W - IDX_W - WORD_SH;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << WORD_SH);

   logic [ADDR_W-1:0] disp, br_tgt, abs_tgt;

   assign seq_pc_o = pc_i + STEP;
   assign disp     = {{(ADDR_W-OFF_W-WORD_SH){offset_i[OFF_W-1]}}, offset_i, {WORD_SH{1'b0}}};
   assign br_tgt   = seq_pc_o + disp;

   generate
      if (REGION_W > 0) begin : g_region
         assign abs_tgt = {seq_pc_o[ADDR_W-1 -: REGION_W], index_i, {WORD_SH{1'b0}}};
      end else begin : g_flat
         assign abs_tgt = {index_i[ADDR_W-WORD_SH-1:0], {WORD_SH{1'b0}}};
      end
      if (DELAY_SLOT) begin : g_skip_slot
         assign link_addr_o = seq_pc_o + STEP;
      end else begin : g_no_slot
         assign link_addr_o = seq_pc_o;
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         K_JUMP, K_CALL:   target_o = abs_tgt;
         K_RJUMP, K_RCALL: target_o = rs_val_i;
         default:          target_o = br_tgt;
      endcase
   end

   // R4: a branch target keeps the low alignment bits of the branch address
   always_comb begin
      if (kind_is_cond(kind_i))
         p_branch_align_r4: assert (target_o[WORD_SH-1:0] == pc_i[WORD_SH-1:0]);
   end
endmodule

// File: rtl/cti_next_pc.sv
module cti_next_pc
   import cti_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 16,
   parameter int IDX_W      = 26,
   parameter int REG_IDX_W  = 5,
   parameter int LINK_REG   = 31,
   parameter bit DELAY_SLOT = 1'b1
) (
   input  logic [ADDR_W-1:0]    pc_i,
   input  logic [5:0]           opcode_i,
   input  logic [REG_IDX_W-1:0] rs_idx_i,
   input  logic [REG_IDX_W-1:0] rt_idx_i,
   input  logic [REG_IDX_W-1:0] rd_idx_i,
   input  logic [5:0]           funct_i,
   input  logic [OFF_W-1:0]     offset_i,
   input  logic [IDX_W-1:0]     index_i,
   input  logic [ADDR_W-1:0]    rs_val_i,
   input  logic [ADDR_W-1:0]    rt_val_i,
   output logic                 taken_o,
   output logic [ADDR_W-1:0]    target_o,
   output logic [ADDR_W-1:0]    next_pc_o,
   output logic                 link_we_o,
   output logic [REG_IDX_W-1:0] link_idx_o,
   output logic [ADDR_W-1:0]    link_addr_o
);
   localparam int LINK_OFF = DELAY_SLOT ? 8 : 4;

   generate
      if (ADDR_W < IDX_W + 2) begin : g_bad_width
         $error("cti_next_pc: ADDR_W too small for the jump index");
      end
      if (OFF_W + 2 > ADDR_W) begin : g_bad_off
         $error("cti_next_pc: OFF_W too wide for ADDR_W");
      end
      if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
         $error("cti_next_pc: LINK_REG outside register file");
      end
   endgenerate

   cti_kind_e         kind;
   logic [ADDR_W-1:0] seq_pc;
   logic              unused_rs_idx;

   assign unused_rs_idx = ^rs_idx_i;

   cti_decode #(.REG_IDX_W(REG_IDX_W)) u_decode (
      .opcode_i (opcode_i),
      .rt_idx_i (rt_idx_i),
      .funct_i  (funct_i),
      .kind_o   (kind)
   );

   cti_cond #(.DATA_W(ADDR_W)) u_cond (
      .kind_i   (kind),
      .rs_val_i (rs_val_i),
      .rt_val_i (rt_val_i),
      .taken_o  (taken_o)
   );

   cti_target #(
      .ADDR_W     (ADDR_W),
      .OFF_W      (OFF_W),
      .IDX_W      (IDX_W),
      .DELAY_SLOT (DELAY_SLOT)
   ) u_target (
      .pc_i        (pc_i),
      .kind_i      (kind),
      .offset_i    (offset_i),
      .index_i     (index_i),
      .rs_val_i    (rs_val_i),
      .seq_pc_o    (seq_pc),
      .target_o    (target_o),
      .link_addr_o (link_addr_o)
   );

   assign link_we_o  = (kind == K_CALL) || (kind == K_RCALL);
   assign link_idx_o = (kind == K_RCALL) ? rd_idx_i : REG_IDX_W'(LINK_REG);
   assign next_pc_o  = taken_o ? target_o : seq_pc;

   // R7: a link request always comes with a redirect and the slot-skipping return address
   always_comb begin
      if (link_we_o) begin
         p_link_taken_r7: assert (taken_o);
         p_link_addr_r7:  assert (link_addr_o == pc_i + ADDR_W'(LINK_OFF));
      end
   end

   // R6: register jumps forward the rs value untouched
   always_comb begin
      if (opcode_i == OP_SPECIAL && (funct_i == FN_RJUMP || funct_i == FN_RCALL))
         p_reg_target_r6: assert (taken_o && target_o == rs_val_i);
   end
endmodule

// File: tb/cti_next_pc_bench.sv
module cti_next_pc_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc, rs_val, rt_val;
   logic [5:0]  opcode, funct;
   logic [4:0]  rs_idx, rt_idx, rd_idx;
   logic [15:0] offset;
   logic [25:0] index;
   logic        taken, link_we;
   logic [31:0] target, next_pc, link_addr;
   logic [4:0]  link_idx;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cti_next_pc u_cti_next_pc (
      .pc_i(pc), .opcode_i(opcode), .rs_idx_i(rs_idx), .rt_idx_i(rt_idx),
      .rd_idx_i(rd_idx), .funct_i(funct), .offset_i(offset), .index_i(index),
      .rs_val_i(rs_val), .rt_val_i(rt_val), .taken_o(taken), .target_o(target),
      .next_pc_o(next_pc), .link_we_o(link_we), .link_idx_o(link_idx),
      .link_addr_o(link_addr)
   );

   task automatic ref_model(output logic e_tk, output logic [31:0] e_tgt,
                            output logic e_we, output logic [4:0] e_idx,
                            output string tag);
      logic [31:0] seq;
      seq   = pc + 32'd4;
      e_tk  = 1'b0;
      e_tgt = 32'hx;
      e_we  = 1'b0;
      e_idx = 5'd0;
      tag   = "R9";
      case (opcode)
         6'd4: begin e_tk = (rs_val == rt_val); tag = "R1"; end
         6'd5: begin e_tk = (rs_val != rt_val); tag = "R1"; end
         6'd6: begin e_tk = ($signed(rs_val) <= 0); tag = "R2"; end
         6'd7: begin e_tk = ($signed(rs_val) > 0);  tag = "R2"; end
         6'd1: begin
            tag = "R3";
            if (rt_idx == 5'd1) e_tk = ($signed(rs_val) >= 0);
            else if (rt_idx == 5'd0) e_tk = ($signed(rs_val) < 0);
         end
         6'd2: begin e_tk = 1'b1; tag = "R5"; end
         6'd3: begin e_tk = 1'b1; e_we = 1'b1; e_idx = 5'd31; tag = "R7"; end
         6'd0: begin
            if (funct == 6'd8) begin e_tk = 1'b1; tag = "R6"; end
            else if (funct == 6'd9) begin e_tk = 1'b1; e_we = 1'b1; e_idx = rd_idx; tag = "R7"; end
         end
         default: ;
      endcase
      if (opcode == 6'd2 || opcode == 6'd3)
         e_tgt = {seq[31:28], index, 2'b00};
      else if (opcode == 6'd0)
         e_tgt = rs_val;
      else
         e_tgt = seq + {{14{offset[15]}}, offset, 2'b00};
   endtask

   task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%08h expected=%08h (op=%0d funct=%0d rt=%0d)",
                  tag, what, act, exp, opcode, funct, rt_idx);
      end
   endtask

   task automatic check_now();
      logic e_tk, e_we;
      logic [31:0] e_tgt;
      logic [4:0] e_idx;
      string tag;
      ref_model(e_tk, e_tgt, e_we, e_idx, tag);
      cmp(tag, "taken", 32'(taken), 32'(e_tk));
      cmp("R8", "next_pc", next_pc, e_tk ? e_tgt : pc + 32'd4);
      if (e_tk || (opcode inside {[6'd4:6'd7]}) || (opcode == 6'd1 && rt_idx < 5'd2))
         cmp(opcode inside {[6'd4:6'd7], 6'd1} ? "R4" : tag, "target", target, e_tgt);
      cmp(e_we ? "R7" : tag, "link_we", 32'(link_we), 32'(e_we));
      if (e_we) begin
         cmp("R7", "link_idx", 32'(link_idx), 32'(e_idx));
         cmp("R7", "link_addr", link_addr, pc + 32'd8);
      end
   endtask

   task automatic apply(logic [31:0] a_pc, logic [5:0] a_op, logic [4:0] a_rt,
                        logic [4:0] a_rd, logic [5:0] a_fn, logic [15:0] a_off,
                        logic [25:0] a_idx, logic [31:0] a_rs, logic [31:0] a_rtv);
      @(negedge clk);
      pc = a_pc; opcode = a_op; rt_idx = a_rt; rd_idx = a_rd; funct = a_fn;
      offset = a_off; index = a_idx; rs_val = a_rs; rt_val = a_rtv;
      rs_idx = 5'd14;
      #(CLK_PERIOD/4);
      check_now();
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom_range(0, 5))
         0: return 32'd0;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'd1;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      pc = '0; opcode = '0; rs_idx = '0; rt_idx = '0; rd_idx = '0; funct = '0;
      offset = '0; index = '0; rs_val = '0; rt_val = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset / idle state: all-zero word is not a transfer (R9, R8)
      @(negedge clk);
      check_now();

      // R1 equal and unequal
      apply(32'h0000_1000, 6'd4, 5'd16, 5'd0, 6'd0, 16'd61, 26'd0, 32'hFFFF_FFEA, 32'hFFFF_FFEA);
      apply(32'h0000_1000, 6'd4, 5'd16, 5'd0, 6'd0, 16'd61, 26'd0, 32'hFFFF_FFEA, 32'd22);
      apply(32'h0000_1000, 6'd5, 5'd15, 5'd0, 6'd0, 16'd61, 26'd0, 32'hFFFF_FFEA, 32'd22);
      apply(32'h0000_1000, 6'd5, 5'd15, 5'd0, 6'd0, 16'd61, 26'd0, 32'd7, 32'd7);
      // R4 backward displacement -4 -> PC-12
      apply(32'h0000_2000, 6'd4, 5'd16, 5'd0, 6'd0, 16'hFFFC, 26'd0, 32'd5, 32'd5);
      // R2 boundaries, rt value ignored
      apply(32'h0000_3000, 6'd6, 5'd0, 5'd0, 6'd0, 16'd8, 26'd0, 32'd0, 32'hDEAD_BEEF);
      apply(32'h0000_3000, 6'd6, 5'd0, 5'd0, 6'd0, 16'd8, 26'd0, 32'd1, 32'd0);
      apply(32'h0000_3000, 6'd7, 5'd0, 5'd0, 6'd0, 16'd8, 26'd0, 32'd0, 32'd5);
      apply(32'h0000_3000, 6'd7, 5'd0, 5'd0, 6'd0, 16'd8, 26'd0, 32'h8000_0000, 32'd5);
      apply(32'h0000_3000, 6'd7, 5'd0, 5'd0, 6'd0, 16'd8, 26'd0, 32'd22, 32'd5);
      // R3 regimm sub-codes
      apply(32'h0000_4000, 6'd1, 5'd1, 5'd0, 6'd0, 16'd61, 26'd0, 32'd22, 32'd0);
      apply(32'h0000_4000, 6'd1, 5'd0, 5'd0, 6'd0, 16'd61, 26'd0, 32'hFFFF_FFEA, 32'd0);
      apply(32'h0000_4000, 6'd1, 5'd0, 5'd0, 6'd0, 16'd61, 26'd0, 32'd0, 32'd0);
      apply(32'h0000_4000, 6'd1, 5'd2, 5'd0, 6'd0, 16'd61, 26'd0, 32'hFFFF_FFEA, 32'd0);
      apply(32'h0000_4000, 6'd1, 5'd17, 5'd0, 6'd0, 16'd61, 26'd0, 32'd22, 32'd0);
      // R5 region jump: index 24 at 0x80000000 -> 0x80000060
      apply(32'h8000_0000, 6'd2, 5'd0, 5'd0, 6'd0, 16'd0, 26'd24, 32'd0, 32'd0);
      apply(32'h8FFF_FFFC, 6'd2, 5'd0, 5'd0, 6'd0, 16'd0, 26'h3FF_FFFF, 32'd0, 32'd0);
      // R6 register jump
      apply(32'h8002_0000, 6'd0, 5'd0, 5'd0, 6'd8, 16'd0, 26'd0, 32'h8004_0000, 32'd0);
      // R7 calls
      apply(32'h8002_0008, 6'd3, 5'd0, 5'd0, 6'd0, 16'd0, 26'h0008012, 32'd0, 32'd0);
      apply(32'h8002_0030, 6'd0, 5'd0, 5'd6, 6'd9, 16'd0, 26'd0, 32'h8002_0058, 32'd0);
      // R9 other functions and opcodes
      apply(32'h0000_5000, 6'd0, 5'd0, 5'd3, 6'd32, 16'd0, 26'd0, 32'h1234, 32'd0);
      apply(32'h0000_5000, 6'd8, 5'd0, 5'd3, 6'd9, 16'd0, 26'd0, 32'h1234, 32'd0);

      for (int i = 0; i < 4000; i++) begin
         logic [5:0] op, fn;
         logic [31:0] a, b;
         op = ($urandom_range(0, 9) == 9) ? 6'($urandom_range(8, 63)) : 6'($urandom_range(0, 7));
         case ($urandom_range(0, 3))
            0: fn = 6'd8;
            1: fn = 6'd9;
            default: fn = 6'($urandom());
         endcase
         a = pick_val();
         b = $urandom_range(0, 1) ? a : pick_val();
         apply({$urandom()} & 32'hFFFF_FFFC, op, 5'($urandom_range(0, 3) == 0 ? $urandom() : $urandom_range(0, 2)),
               5'($urandom()), fn, 16'($urandom()), 26'($urandom()), a, b);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule